// File: doc/BRIEF.md
# Output Over-Voltage Protection Sequencer

This block guards the output of an isolated converter against over-voltage. Once per switching cycle it receives a sampled auxiliary-winding voltage, already reduced to four comparator flags. Each flag compares the sample with a fixed fraction of the voltage-loop reference: under 80 %, over 105 %, over 115 % and over 130 %. A strobe marks the cycle in which the flags are valid. From the runs of consecutive strobes, the block decides whether switching must pause and whether a fault must be raised.

The slow protection stops normal switching after a run of high samples. While it is active, the block asks the gate driver for one refresh pulse per programmable period, so that a fresh sample arrives. It releases switching when a sample falls back below the 105 % level. The fast protection raises a sticky fault request after a run of samples above 130 %. This run is shorter once the slow protection has engaged at least once since the last reset or restart. A separate flag tells the voltage loop to speed up while the sample is below 80 %.

The refresh period is counted in tick enables from a shared time base. A restart pulse from the recovery logic clears the fault and all history.

Top module: `ovp_guard`

## Requirements
- R1: After reset, sw_inhibit, refresh_req, fault_req and boost are all low.
- R2: On each cycle with sample_vld high, boost takes the value of lo_80. It holds that value on all other cycles. The change is visible in the cycle after the strobe.
- R3: The slow protection engages, and sw_inhibit rises, on the SLOW_CYCLES-th consecutive strobe with hi_115 high (default 4). A strobe with hi_115 low restarts the run. Cycles without a strobe neither advance nor break the run.
- R4: While the slow protection is active, sw_inhibit stays high. refresh_req is a one-clock pulse after every REFRESH_TICKS tick enables counted since engagement.
- R5: An active slow protection ends on a strobe with hi_105 low. A strobe with hi_105 high keeps it active.
- R6: If the slow protection has not engaged since the last reset or restart, fault_req rises on the FAST_CYCLES-th consecutive strobe with hi_130 high (default 4).
- R7: Once the slow protection has engaged since the last reset or restart, fault_req rises on the FAST_ARMED_CYCLES-th consecutive strobe with hi_130 high (default 2).
- R8: fault_req stays high until restart and holds sw_inhibit high meanwhile. A restart pulse clears fault_req and sw_inhibit in the next cycle.
- R9: A restart clears the slow-engaged history, so the longer fast run of R6 applies again.
- R10: Tick enables while the slow protection is inactive produce no refresh_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick enable for the refresh period |
| restart | input | 1 | One-clock pulse at the start of a recovery restart |
| sample_vld | input | 1 | Comparator flags valid for this switching cycle |
| lo_80 | input | 1 | Sample below 80 % of reference |
| hi_105 | input | 1 | Sample above 105 % of reference |
| hi_115 | input | 1 | Sample above 115 % of reference |
| hi_130 | input | 1 | Sample above 130 % of reference |
| sw_inhibit | output | 1 | Normal switching must stop |
| refresh_req | output | 1 | One-clock request for a single refresh pulse |
| fault_req | output | 1 | Fast over-voltage fault, sticky until restart |
| boost | output | 1 | Speed up the voltage loop |

## Verification
Every result is registered once. So boost, sw_inhibit and fault_req settle in the cycle after the strobe or restart that causes them, and refresh_req is high in the cycle after the tick that completes a period. The bench drives each stimulus for one clock from a falling edge and reads the outputs at the next falling edge, which is exactly one rising edge later. The run-length sweeps check the outputs after every single strobe, so a threshold that is off by one shows up in the expected count.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef struct packed {
    logic under_80;
    logic over_105;
    logic over_115;
    logic over_130;
  } cmp_flags_t;
endpackage

// File: rtl/ovp_run_counter.sv
// Saturating count of consecutive valid samples that carry a hit.
module ovp_run_counter #(
  parameter int LIMIT = 4,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic         hit,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(LIMIT);
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr) begin
      count_d = '0;
    end else if (vld) begin
      if (!hit)             count_d = '0;
      else if (count != TOP) count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/ovp_refresh_timer.sv
// Counts tick enables while run is high; pulses once per PERIOD ticks.
module ovp_refresh_timer #(
  parameter int PERIOD = 1400,
  localparam int W = (PERIOD < 2) ? 1 : $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic pulse
);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/ovp_guard.sv
module ovp_guard #(
  parameter int SLOW_CYCLES       = 4,
  parameter int FAST_CYCLES       = 4,
  parameter int FAST_ARMED_CYCLES = 2,
  parameter int REFRESH_TICKS     = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  input  logic sample_vld,
  input  logic lo_80,
  input  logic hi_105,
  input  logic hi_115,
  input  logic hi_130,
  output logic sw_inhibit,
  output logic refresh_req,
  output logic fault_req,
  output logic boost
);
  import ovp_pkg::*;

  localparam int SW = $clog2(SLOW_CYCLES + 1);
  localparam int FW = $clog2(FAST_CYCLES + 1);
  localparam logic [SW-1:0] SLOW_LAST  = SW'(SLOW_CYCLES - 1);
  localparam logic [FW-1:0] FAST_LAST  = FW'(FAST_CYCLES - 1);
  localparam logic [FW-1:0] ARMED_LAST = FW'(FAST_ARMED_CYCLES - 1);

  cmp_flags_t    flags;
  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] fast_cnt;
  logic [FW-1:0] fast_last;
  logic          slow_q, slow_d;
  logic          armed_q, armed_d;
  logic          fault_q, fault_d;
  logic          boost_q, boost_d;
  logic          engage, release_ok, fast_fire;

  assign flags = '{under_80: lo_80, over_105: hi_105,
                   over_115: hi_115, over_130: hi_130};

  ovp_run_counter #(.LIMIT(SLOW_CYCLES)) i_slow_run (
    .clk(clk), .rst_n(rst_n), .clr(restart),
    .vld(sample_vld), .hit(flags.over_115), .count(slow_cnt)
  );

  ovp_run_counter #(.LIMIT(FAST_CYCLES)) i_fast_run (
    .clk(clk), .rst_n(rst_n), .clr(restart),
    .vld(sample_vld), .hit(flags.over_130), .count(fast_cnt)
  );

  ovp_refresh_timer #(.PERIOD(REFRESH_TICKS)) i_refresh (
    .clk(clk), .rst_n(rst_n), .run(slow_q),
    .tick(tick_en), .pulse(refresh_req)
  );

  always_comb begin
    fast_last  = armed_q ? ARMED_LAST : FAST_LAST;
    engage     = !slow_q && sample_vld && flags.over_115 && (slow_cnt >= SLOW_LAST);
    release_ok = slow_q && sample_vld && !flags.over_105;
    fast_fire  = sample_vld && flags.over_130 && (fast_cnt >= fast_last);

    slow_d  = slow_q;
    armed_d = armed_q;
    fault_d = fault_q;
    boost_d = sample_vld ? flags.under_80 : boost_q;

    if (restart) begin
      slow_d  = 1'b0;
      armed_d = 1'b0;
      fault_d = 1'b0;
    end else begin
      if (release_ok)  slow_d = 1'b0;
      else if (engage) begin
        slow_d  = 1'b1;
        armed_d = 1'b1;
      end
      if (fast_fire) fault_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q  <= 1'b0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
      boost_q <= 1'b0;
    end else begin
      slow_q  <= slow_d;
      armed_q <= armed_d;
      fault_q <= fault_d;
      boost_q <= boost_d;
    end
  end

  assign sw_inhibit = slow_q | fault_q;
  assign fault_req  = fault_q;
  assign boost      = boost_q;
endmodule

// File: rtl/ovp_guard_chk.sv
module ovp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic sample_vld,
  input logic hi_115,
  input logic hi_130,
  input logic sw_inhibit,
  input logic refresh_req,
  input logic fault_req,
  input logic boost
);
  assert_boost_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(boost));

  assert_inhibit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_inhibit) |-> $past(sample_vld && (hi_115 || hi_130)));

  assert_refresh_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  assert_refresh_only_inhibited_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> $past(sw_inhibit));

  assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_req) |-> $past(sample_vld && hi_130));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !restart) |=> fault_req);

  assert_fault_inhibits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> sw_inhibit);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!fault_req && !sw_inhibit));
endmodule

bind ovp_guard ovp_guard_chk i_ovp_guard_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sample_vld(sample_vld),
  .hi_115(hi_115), .hi_130(hi_130), .sw_inhibit(sw_inhibit),
  .refresh_req(refresh_req), .fault_req(fault_req), .boost(boost)
);

// File: tb/test_ovp_guard.sv
`timescale 1ns/1ps
module test_ovp_guard;
  localparam int PER = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, restart = 1'b0, sample_vld = 1'b0;
  logic lo_80 = 1'b0, hi_105 = 1'b0, hi_115 = 1'b0, hi_130 = 1'b0;
  logic sw_inhibit, refresh_req, fault_req, boost;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ovp_guard #(.SLOW_CYCLES(4), .FAST_CYCLES(4), .FAST_ARMED_CYCLES(2),
              .REFRESH_TICKS(PER)) i_ovp_guard (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .sample_vld(sample_vld), .lo_80(lo_80), .hi_105(hi_105),
    .hi_115(hi_115), .hi_130(hi_130), .sw_inhibit(sw_inhibit),
    .refresh_req(refresh_req), .fault_req(fault_req), .boost(boost)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One strobe; outputs are read one rising edge later.
  task automatic strobe(input logic u80, input logic h105, input logic h115, input logic h130);
    @(negedge clk);
    sample_vld = 1'b1; lo_80 = u80; hi_105 = h105; hi_115 = h115; hi_130 = h130;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic arm_slow();
    for (int i = 0; i < 4; i++) strobe(1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    idle(3);
    check("R1 inhibit", sw_inhibit, 1'b0);
    check("R1 refresh", refresh_req, 1'b0);
    check("R1 fault", fault_req, 1'b0);
    check("R1 boost", boost, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R2: boost follows lo_80 at strobes only
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 set", boost, 1'b1);
    lo_80 = 1'b0; idle(4);
    check("R2 hold", boost, 1'b1);
    strobe(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 clear", boost, 1'b0);

    // R3: run-length sweep for slow engagement
    for (int len = 1; len <= 6; len++) begin
      do_restart();
      for (int k = 1; k <= len; k++) begin
        strobe(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 sweep", sw_inhibit, (k >= 4));
      end
      strobe(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5 exit", sw_inhibit, 1'b0);
    end

    // R3: idle gaps do not break the run, a miss does
    do_restart();
    for (int k = 0; k < 3; k++) strobe(1'b0, 1'b1, 1'b1, 1'b0);
    idle(10);
    strobe(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 gap", sw_inhibit, 1'b1);
    do_restart();
    for (int k = 0; k < 3; k++) strobe(1'b0, 1'b1, 1'b1, 1'b0);
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) strobe(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 miss", sw_inhibit, 1'b0);
    strobe(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 refill", sw_inhibit, 1'b1);

    // R4: refresh pulses every PER ticks while active
    for (int t = 1; t <= 3 * PER; t++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      check("R4 refresh", refresh_req, (t % PER) == 0);
      check("R4 inhibit", sw_inhibit, 1'b1);
      @(negedge clk);
      check("R4 width", refresh_req, 1'b0);
    end

    // R5: still above 105 keeps it, below releases
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 hold", sw_inhibit, 1'b1);
    strobe(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 release", sw_inhibit, 1'b0);

    // R10: ticks with slow inactive
    for (int t = 1; t <= 2 * PER; t++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      check("R10 no refresh", refresh_req, 1'b0);
    end

    // R6 / R7: fast run sweep, unarmed and armed
    for (int armed = 0; armed < 2; armed++) begin
      for (int len = 1; len <= 5; len++) begin
        do_restart();
        if (armed == 1) begin
          arm_slow();
          strobe(1'b0, 1'b0, 1'b0, 1'b0);
        end
        for (int k = 1; k <= len; k++) begin
          strobe(1'b0, 1'b1, 1'b1, 1'b1);
          if (armed == 1) check("R7 armed", fault_req, (k >= 2));
          else            check("R6 unarmed", fault_req, (k >= 4));
        end
      end
    end

    // R8: fault sticky, inhibits, cleared by restart
    strobe(1'b0, 1'b0, 1'b0, 1'b0);
    idle(5);
    check("R8 sticky", fault_req, 1'b1);
    check("R8 inhibit", sw_inhibit, 1'b1);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check("R8 cleared", fault_req, 1'b0);
    check("R8 inhibit cleared", sw_inhibit, 1'b0);

    // R9: restart forgets slow history
    arm_slow();
    strobe(1'b0, 1'b0, 1'b0, 1'b0);
    do_restart();
    for (int k = 1; k <= 4; k++) begin
      strobe(1'b0, 1'b1, 1'b0, 1'b1);
      check("R9 history cleared", fault_req, (k >= 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule